// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block moves a raw NAND flash device into one of several read-retry modes. It drives a byte-wide bus that carries command, address and data cycles. A start pulse supplies a mode index and a register count. The block then writes every retry register of the device, in order, through a private write path: it sends an opening command byte, then one address cycle and one data cycle per register, then a commit command that makes the device use the new values. The block reports the result with a one-cycle done or error pulse.

The value for each register comes from a flat byte table laid out mode-major. Each mode owns `nregs` consecutive entries, so the stride between modes follows the register count of the current request. The register offsets come from a built-in eight-entry list or from an input port, as an elaboration parameter selects. Each bus cycle completes on a valid/ready handshake. When a cycle is returned with a failure flag, the sequence stops at once and the commit command is not sent.

Top module: `rr_param_seq`

## Requirements
- R1: After a start is accepted, the first bus cycle is a command cycle (kind code 0) carrying byte 0x36.
- R2: Each register is written as exactly one address cycle (kind code 1) carrying its offset, followed at once by one data cycle (kind code 2) carrying its value. Registers are written in slot order 0 to nregs-1.
- R3: For mode m and register slot i, the data byte is table entry m*nregs + i, where entry j occupies bits [8j+7:8j] of the value table.
- R4: After the last register write, a command cycle carrying byte 0x16 is issued. done_o pulses for one cycle in the cycle after that cycle's handshake.
- R5: With the built-in list (FIXED_REGS=1), slots 0..7 use offsets 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF in that order, and reg_addr_i has no effect.
- R6: A handshake with bus_err_i high ends the sequence after that cycle. err_o pulses in the next cycle, no further cycle (and so no 0x16 command) is issued, and done_o stays low.
- R7: A start with mode_i >= NUM_MODES or nregs_i > MAX_REGS issues no bus cycle, keeps busy_o low and pulses err_o in the next cycle.
- R8: busy_o is high from the cycle after an accepted start until done_o or err_o pulses, and a start that arrives while busy_o is high is ignored.
- R9: While bus_valid_o is high and bus_ready_i is low, bus_valid_o, bus_kind_o and bus_byte_o hold their values into the next cycle.
- R10: With nregs_i = 0, the sequence is only the 0x36 command followed by the 0x16 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| mode_i | input | MODE_W | Retry mode index |
| nregs_i | input | $clog2(MAX_REGS+1) | Number of registers to write |
| reg_addr_i | input | MAX_REGS*8 | Register offsets, slot i at bits [8i+7:8i]; used only when FIXED_REGS=0 |
| value_tab_i | input | NUM_MODES*MAX_REGS*8 | Mode-major value table, must stay stable while busy |
| bus_valid_o | output | 1 | A bus cycle is offered |
| bus_kind_o | output | 2 | Cycle kind: 0 command, 1 address, 2 data |
| bus_byte_o | output | 8 | Byte of the offered cycle |
| bus_ready_i | input | 1 | Device side accepts the offered cycle |
| bus_err_i | input | 1 | Accepted cycle failed (qualified by bus_ready_i) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: sequence committed |
| err_o | output | 1 | One-cycle pulse: request rejected or aborted |

## Verification
Table values are all distinct and differ between neighbouring entries. A wrong stride (fixed eight instead of nregs) or an off-by-one slot therefore produces a wrong data byte, and register counts of 0, 3, 4 and 8 are used against modes 0, 1, 2, 5 and 7. The sequences run with ready held high and with a periodic stall pattern, which separates correct holding of the offered cycle from a design that advances without a handshake. Failures are injected on the opening command and on a mid-sequence address cycle. Out-of-range modes and counts are requested, and a second start is issued during a run. These cases tell a clean abort from one that leaks the commit command or accepts a new request.

// File: rtl/rr_seq_pkg.sv
package rr_seq_pkg;

   localparam int BUS_W = 8;

   typedef enum logic [1:0] {
      BK_CMD  = 2'd0,
      BK_ADDR = 2'd1,
      BK_DATA = 2'd2
   } bus_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_ADDR,
      ST_DATA,
      ST_APPLY
   } seq_state_e;

   localparam logic [BUS_W-1:0] OP_OPEN  = 8'h36;
   localparam logic [BUS_W-1:0] OP_APPLY = 8'h16;

endpackage

// File: rtl/rr_offset_src.sv
module rr_offset_src #(
   parameter int MAX_REGS   = 8,
   parameter int FIXED_REGS = 1,
   parameter int SLOT_W     = 3
) (
   input  logic [MAX_REGS*rr_seq_pkg::BUS_W-1:0] reg_addr_i,
   input  logic [SLOT_W-1:0]                     slot_i,
   output logic [rr_seq_pkg::BUS_W-1:0]          offset_o
);
   import rr_seq_pkg::*;

   generate
      if (FIXED_REGS != 0) begin : g_fixed
         logic unused_port;
         assign unused_port = ^reg_addr_i;
         always_comb begin
            case (32'(slot_i))
               0:       offset_o = 8'hCC;
               1:       offset_o = 8'hBF;
               2:       offset_o = 8'hAA;
               3:       offset_o = 8'hAB;
               4:       offset_o = 8'hCD;
               5:       offset_o = 8'hAD;
               6:       offset_o = 8'hAE;
               7:       offset_o = 8'hAF;
               default: offset_o = '0;
            endcase
         end
      end else begin : g_port
         logic [BUS_W-1:0] entries [MAX_REGS];
         for (genvar g = 0; g < MAX_REGS; g++) begin : g_ent
            assign entries[g] = reg_addr_i[g*BUS_W +: BUS_W];
         end
         always_comb begin
            offset_o = '0;
            if (32'(slot_i) < MAX_REGS) offset_o = entries[slot_i];
         end
      end
   endgenerate

endmodule

// File: rtl/rr_value_pick.sv
module rr_value_pick #(
   parameter int NUM_MODES = 8,
   parameter int MAX_REGS  = 8,
   parameter int MODE_W    = 4,
   parameter int NREG_W    = 4,
   parameter int SLOT_W    = 3
) (
   input  logic [NUM_MODES*MAX_REGS*rr_seq_pkg::BUS_W-1:0] value_tab_i,
   input  logic [MODE_W-1:0]                               mode_i,
   input  logic [NREG_W-1:0]                               nregs_i,
   input  logic [SLOT_W-1:0]                               slot_i,
   output logic [rr_seq_pkg::BUS_W-1:0]                    value_o
);
   import rr_seq_pkg::*;

   localparam int TAB_N  = NUM_MODES * MAX_REGS;
   localparam int IDX_W  = (TAB_N > 1) ? $clog2(TAB_N) : 1;
   localparam int PROD_W = MODE_W + NREG_W + 1;

   logic [BUS_W-1:0]  entries [TAB_N];
   logic [PROD_W-1:0] flat_idx;

   for (genvar g = 0; g < TAB_N; g++) begin : g_ent
      assign entries[g] = value_tab_i[g*BUS_W +: BUS_W];
   end

   // mode-major layout: stride between modes equals the live register count
   assign flat_idx = PROD_W'(mode_i) * PROD_W'(nregs_i) + PROD_W'(slot_i);

   always_comb begin
      value_o = '0;
      if (flat_idx < PROD_W'(TAB_N)) value_o = entries[flat_idx[IDX_W-1:0]];
   end

endmodule

// File: rtl/rr_param_seq.sv
module rr_param_seq #(
   parameter int NUM_MODES  = 8,
   parameter int MAX_REGS   = 8,
   parameter int MODE_W     = 4,
   parameter int FIXED_REGS = 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start_i,
   input  logic [MODE_W-1:0]                   mode_i,
   input  logic [$clog2(MAX_REGS+1)-1:0]       nregs_i,
   input  logic [MAX_REGS*8-1:0]               reg_addr_i,
   input  logic [NUM_MODES*MAX_REGS*8-1:0]     value_tab_i,
   output logic                                bus_valid_o,
   output logic [1:0]                          bus_kind_o,
   output logic [7:0]                          bus_byte_o,
   input  logic                                bus_ready_i,
   input  logic                                bus_err_i,
   output logic                                busy_o,
   output logic                                done_o,
   output logic                                err_o
);
   import rr_seq_pkg::*;

   localparam int NREG_W = $clog2(MAX_REGS + 1);
   localparam int SLOT_W = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

   generate
      if (NUM_MODES < 1) begin : g_bad_modes
         $error("NUM_MODES must be at least 1");
      end
      if (MAX_REGS < 1) begin : g_bad_regs
         $error("MAX_REGS must be at least 1");
      end
      if (FIXED_REGS != 0 && MAX_REGS > 8) begin : g_bad_list
         $error("built-in offset list holds only 8 entries");
      end
      if ((1 << MODE_W) < NUM_MODES) begin : g_bad_modew
         $error("MODE_W too narrow for NUM_MODES");
      end
   endgenerate

   seq_state_e        state_q;
   logic [MODE_W-1:0] mode_q;
   logic [NREG_W-1:0] nregs_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BUS_W-1:0]  offset_w;
   logic [BUS_W-1:0]  value_w;
   logic              req_bad;
   logic              last_slot;
   logic              beat_ok;

   rr_offset_src #(
      .MAX_REGS  (MAX_REGS),
      .FIXED_REGS(FIXED_REGS),
      .SLOT_W    (SLOT_W)
   ) u_offs (
      .reg_addr_i(reg_addr_i),
      .slot_i    (slot_q),
      .offset_o  (offset_w)
   );

   rr_value_pick #(
      .NUM_MODES(NUM_MODES),
      .MAX_REGS (MAX_REGS),
      .MODE_W   (MODE_W),
      .NREG_W   (NREG_W),
      .SLOT_W   (SLOT_W)
   ) u_vals (
      .value_tab_i(value_tab_i),
      .mode_i     (mode_q),
      .nregs_i    (nregs_q),
      .slot_i     (slot_q),
      .value_o    (value_w)
   );

   assign req_bad   = ({1'b0, mode_i} >= (MODE_W+1)'(NUM_MODES)) ||
                      (nregs_i > NREG_W'(MAX_REGS));
   assign last_slot = (NREG_W'(slot_q) + NREG_W'(1)) == nregs_q;
   assign beat_ok   = bus_valid_o && bus_ready_i;

   always_comb begin
      bus_valid_o = 1'b1;
      bus_kind_o  = BK_CMD;
      bus_byte_o  = '0;
      case (state_q)
         ST_OPEN:  bus_byte_o = OP_OPEN;
         ST_ADDR:  begin bus_kind_o = BK_ADDR; bus_byte_o = offset_w; end
         ST_DATA:  begin bus_kind_o = BK_DATA; bus_byte_o = value_w;  end
         ST_APPLY: bus_byte_o = OP_APPLY;
         default:  bus_valid_o = 1'b0;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         nregs_q <= '0;
         slot_q  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (start_i) begin
               if (req_bad) begin
                  err_o <= 1'b1;
               end else begin
                  mode_q  <= mode_i;
                  nregs_q <= nregs_i;
                  slot_q  <= '0;
                  state_q <= ST_OPEN;
               end
            end
         end else if (beat_ok) begin
            if (bus_err_i) begin
               err_o   <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               case (state_q)
                  ST_OPEN: state_q <= (nregs_q == '0) ? ST_APPLY : ST_ADDR;
                  ST_ADDR: state_q <= ST_DATA;
                  ST_DATA: begin
                     if (last_slot) begin
                        state_q <= ST_APPLY;
                     end else begin
                        slot_q  <= slot_q + SLOT_W'(1);
                        state_q <= ST_ADDR;
                     end
                  end
                  default: begin
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               endcase
            end
         end
      end
   end

   AST_OPEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (bus_valid_o && bus_kind_o == BK_CMD && bus_byte_o == OP_OPEN)); // R1

   AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && !bus_err_i && bus_kind_o == BK_ADDR) |=> (bus_valid_o && bus_kind_o == BK_DATA)); // R2

   AST_DONE_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(beat_ok && !bus_err_i && bus_kind_o == BK_CMD && bus_byte_o == OP_APPLY)); // R4

   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && bus_err_i) |=> (!bus_valid_o && err_o && !done_o)); // R6

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && req_bad) |=> (!busy_o && err_o)); // R7

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_kind_o) && $stable(bus_byte_o))); // R9

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R8

endmodule

// File: tb/tb_rr_param_seq.sv
`timescale 1ns/1ps
module tb_rr_param_seq;

   localparam int NM = 8;
   localparam int MR = 8;
   localparam int MW = 4;
   localparam int NW = $clog2(MR+1);

   typedef struct {
      logic [1:0] kind;
      logic [7:0] data;
      string      req;
   } beat_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [MW-1:0] mode_i = '0;
   logic [NW-1:0] nregs_i = '0;
   logic [MR*8-1:0] reg_addr_i;
   logic [NM*MR*8-1:0] value_tab_i;
   logic bus_valid_o;
   logic [1:0] bus_kind_o;
   logic [7:0] bus_byte_o;
   logic bus_ready_i = 1'b1;
   logic bus_err_i = 1'b0;
   logic busy_o, done_o, err_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int beat_cnt = 0;
   int inject_at = -1;
   bit stall = 1'b0;
   bit was_stalled = 1'b0;
   logic [1:0] held_kind;
   logic [7:0] held_byte;
   beat_t exp_q[$];

   always #2.5 clk = ~clk;

   rr_param_seq #(.NUM_MODES(NM), .MAX_REGS(MR), .MODE_W(MW), .FIXED_REGS(1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .nregs_i(nregs_i),
      .reg_addr_i(reg_addr_i), .value_tab_i(value_tab_i),
      .bus_valid_o(bus_valid_o), .bus_kind_o(bus_kind_o), .bus_byte_o(bus_byte_o),
      .bus_ready_i(bus_ready_i), .bus_err_i(bus_err_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

   function automatic logic [7:0] tab_val(int j);
      return 8'((j * 37 + 5) & 255);
   endfunction

   function automatic logic [7:0] fixed_off(int i);
      logic [7:0] lst [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
      return lst[i];
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // watchdog and cycle counter
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // device-side responder: drives after the edge
   always @(posedge clk) begin
      #1;
      bus_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
      bus_err_i   = (inject_at >= 0) && (beat_cnt == inject_at);
   end

   // monitor: pops expected beats and compares on each handshake
   always @(negedge clk) begin
      if (rst_n) begin
         if (was_stalled) begin
            // R9: stalled cycle must be held
            check(bus_valid_o && bus_kind_o == held_kind && bus_byte_o == held_byte,
                  "R9", "stalled beat not held", {bus_kind_o, bus_byte_o}, {held_kind, held_byte});
         end
         was_stalled = bus_valid_o && !bus_ready_i;
         held_kind = bus_kind_o;
         held_byte = bus_byte_o;
         if (bus_valid_o && bus_ready_i) begin
            beat_cnt++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R6/R7", "unexpected bus beat", {bus_kind_o, bus_byte_o}, 0);
            end else begin
               beat_t e;
               e = exp_q.pop_front();
               check(bus_kind_o == e.kind && bus_byte_o == e.data, e.req, "beat",
                     {bus_kind_o, bus_byte_o}, {e.kind, e.data});
            end
         end
      end
   end

   task automatic run(int m, int n, bit stl, int err_beat, bit extra_start);
      bit reject;
      bit exp_err;
      bit got_done;
      bit got_err;
      beat_t items[$];
      beat_t b;
      reject = (m >= NM) || (n > MR);
      if (!reject) begin
         b.kind = 2'd0; b.data = 8'h36; b.req = "R1"; items.push_back(b);
         for (int i = 0; i < n; i++) begin
            b.kind = 2'd1; b.data = fixed_off(i); b.req = "R2/R5"; items.push_back(b);
            b.kind = 2'd2; b.data = tab_val(m * n + i); b.req = "R3"; items.push_back(b);
         end
         b.kind = 2'd0; b.data = 8'h16; b.req = (n == 0) ? "R10" : "R4"; items.push_back(b);
         if (err_beat >= 0) begin
            while (items.size() > err_beat + 1) void'(items.pop_back());
         end
      end
      exp_err = reject || (err_beat >= 0);
      @(posedge clk); #1;
      foreach (items[k]) exp_q.push_back(items[k]);
      stall = stl;
      beat_cnt = 0;
      inject_at = err_beat;
      start_i = 1'b1;
      mode_i = MW'(m);
      nregs_i = NW'(n);
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      // R8 / R7: busy right after start
      check(busy_o == !reject, reject ? "R7" : "R8", "busy after start", busy_o, !reject);
      if (extra_start) begin
         repeat (2) @(posedge clk);
         #1;
         start_i = 1'b1; mode_i = 4'd3; nregs_i = 4'd2;  // R8: must be ignored
         @(posedge clk); #1;
         start_i = 1'b0;
      end
      got_done = 1'b0;
      got_err = 1'b0;
      for (int t = 0; t < 400; t++) begin
         if (done_o || err_o) begin
            got_done = done_o;
            got_err = err_o;
            break;
         end
         @(negedge clk);
      end
      check(got_err == exp_err && got_done == !exp_err, exp_err ? "R6" : "R4",
            "outcome {done,err}", {got_done, got_err}, {!exp_err, exp_err});
      check(busy_o == 1'b0, "R8", "busy after outcome", busy_o, 0);
      check(exp_q.size() == 0, "R2", "expected beats left", exp_q.size(), 0);
      exp_q.delete();
      inject_at = -1;
      stall = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      for (int j = 0; j < NM * MR; j++) value_tab_i[j*8 +: 8] = tab_val(j);
      reg_addr_i = {MR{8'h5A}};  // R5: port ignored with built-in list
      repeat (5) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !bus_valid_o && !done_o && !err_o, "R8", "reset state",
            {busy_o, bus_valid_o, done_o, err_o}, 0);
      run(0, 8, 1'b0, -1, 1'b0);   // R5 full list, R3 mode 0
      run(5, 3, 1'b1, -1, 1'b0);   // R3 stride 3, R9 stalls
      run(7, 8, 1'b1, -1, 1'b0);   // R3 last entry
      run(2, 0, 1'b0, -1, 1'b0);   // R10
      run(8, 4, 1'b0, -1, 1'b0);   // R7 mode out of range
      run(1, 9, 1'b0, -1, 1'b0);   // R7 count out of range
      run(1, 4, 1'b1, 3, 1'b0);    // R6 abort on address of slot 1
      run(4, 2, 1'b0, 0, 1'b0);    // R6 abort on opening command
      run(6, 8, 1'b0, -1, 1'b1);   // R8 start while busy
      run(3, 2, 1'b1, -1, 1'b0);   // normal run after errors
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule